// File: doc/BRIEF.md
# Clock Path Power-Down Controller

This block produces the power-down enables for the output clock paths of two PLLs. PLL A has five post-divider outputs that can each be switched off independently. PLL B has a single doubled-frequency output. Software sets one request bit per path through a small register port. The block then turns those requests into power-down outputs that are safe to apply to the analog clock paths.

A request takes effect only while the path's output clock is gated, so the path never drops while a clock edge could still reach a consumer. A request made while the gate is open stays pending and raises a sticky error flag for that path. When a PLL is in stop mode, every path of that PLL goes down whatever the request bits and gate states are. Once a path is down, it is held down for a minimum number of cycles before it may come back up, which gives the analog path time to settle. A status word reports the effective power-down state and the error flags of all paths.

Top module: `clkpath_pd_ctrl`

## Requirements
- R1: Address 0 holds the PLL A request bits in bits 31:27 (bit 27 is path A0 and bit 31 is path A4). Address 1 holds the PLL B request in bit 12. All other bits of these words read as zero. Read data appears on the clock edge after the address is presented.
- R2: A read of address 2 returns the status word. Bits 4:0 are the power-down outputs of A0..A4, bit 5 is that of B, bits 12:8 are the error flags of A0..A4, bit 13 is the error flag of B, and all other bits are zero.
- R3: A request bit written while its gate-status input is low (gated) asserts that path's power-down output on the next clock edge after the write edge.
- R4: A request made while the gate-status input is high (clock running) leaves the power-down output low. The output asserts on the first clock edge after the gate-status input goes low.
- R5: A request pending with an open gate sets that path's sticky error flag. The flag stays set until reset, even after the request completes or is cleared.
- R6: A PLL mode input equal to 2'b00 (stop) forces every path of that PLL down on the next edge, regardless of request bits and gate states, and sets no error flag. Mode values 2'b01, 2'b10 and 2'b11 force nothing. Stop mode on one PLL does not affect the other PLL.
- R7: Once a power-down output rises, it stays high for at least HOLD_CYCLES clock cycles (16 by default). It falls on the first edge at which the hold has elapsed and neither a request nor stop mode is active.
- R8: The power-down output of each path depends only on its own request bit, its own gate-status input and its own PLL's mode.
- R9: Synchronous active-high reset clears all request bits, power-down outputs, error flags and read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register address (0: PLL A, 1: PLL B, 2: status) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| pll_a_mode | input | 2 | PLL A operating mode (2'b00 = stop) |
| pll_b_mode | input | 2 | PLL B operating mode (2'b00 = stop) |
| gate_open_a | input | 5 | Output-clock gate status per PLL A path, high = running |
| gate_open_b | input | 1 | Output-clock gate status of the PLL B path |
| pd_a | output | 5 | Registered power-down outputs of paths A0..A4 |
| pd_b | output | 1 | Registered power-down output of path B |

## Verification
If a path's hold counter is wrong, that path's output falls one or more cycles early or late. This is visible on pd_a or pd_b exactly HOLD_CYCLES edges after the rise. The bench samples every cycle of the hold window, so an off-by-one shows up at once. If the gate qualification is wrong, a path rises on the cycle after a write while its gate is open. If stop-mode forcing is wrong, a path fails to rise on the edge after the mode change. A wrong error flag shows in the status word on the next read. Sweeping all 32 request patterns exposes any crossed or shared path state as a mismatch in another path's output bit.

// File: rtl/clkpath_pd_pkg.sv
package clkpath_pd_pkg;
  localparam int A_PATHS   = 5;
  localparam int A_LSB     = 27;
  localparam int B_BIT     = 12;
  localparam int ERR_LSB   = 8;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 2;

  localparam logic [ADDR_W-1:0] ADDR_A    = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_B    = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  typedef enum logic [1:0] {
    MODE_STOP   = 2'b00,
    MODE_BYPASS = 2'b01,
    MODE_RELOCK = 2'b10,
    MODE_LOCKED = 2'b11
  } pll_mode_e;
endpackage

// File: rtl/clkpath_pd_regs.sv
module clkpath_pd_regs
  import clkpath_pd_pkg::*;
#(
  parameter int N_A   = A_PATHS,
  parameter int LSB_A = A_LSB,
  parameter int BIT_B = B_BIT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] status,
  output logic [N_A-1:0]    sw_a,
  output logic              sw_b,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_a <= '0;
      sw_b <= 1'b0;
    end else if (wr) begin
      if (addr == ADDR_A) sw_a <= wdata[LSB_A +: N_A];
      if (addr == ADDR_B) sw_b <= wdata[BIT_B];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_A:    rd_mux[LSB_A +: N_A] = sw_a;
      ADDR_B:    rd_mux[BIT_B] = sw_b;
      ADDR_STAT: rd_mux = status;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  AST_RSVD_A_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == ADDR_A) |-> (rdata[LSB_A-1:0] == '0)); // R1
  AST_RSVD_B_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == ADDR_B) |-> ($countones(rdata) <= 1)); // R1
endmodule

// File: rtl/clkpath_pd_path.sv
module clkpath_pd_path #(
  parameter int HOLD_CYCLES = 16,
  localparam int CW = $clog2(HOLD_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic req_sw,
  input  logic force_stop,
  input  logic gate_open,
  output logic pd,
  output logic err
);
  logic [CW-1:0] hold_cnt;
  logic          enter_ok;

  assign enter_ok = force_stop || (req_sw && !gate_open);

  always_ff @(posedge clk) begin
    if (rst) begin
      pd       <= 1'b0;
      hold_cnt <= '0;
      err      <= 1'b0;
    end else if (!pd) begin
      if (enter_ok) begin
        pd       <= 1'b1;
        hold_cnt <= CW'(HOLD_CYCLES - 1);
      end else if (req_sw) begin
        err <= 1'b1;
      end
    end else begin
      if (hold_cnt != '0)              hold_cnt <= hold_cnt - 1'b1;
      else if (!req_sw && !force_stop) pd <= 1'b0;
    end
  end

  // Independent age tracker used only by the hold check below.
  logic [CW-1:0] age;
  always_ff @(posedge clk) begin
    if (rst)                          age <= '0;
    else if (!pd)                     age <= '0;
    else if (age != CW'(HOLD_CYCLES)) age <= age + 1'b1;
  end

  AST_GATED_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(pd) |-> $past(force_stop || (req_sw && !gate_open))); // R4
  AST_STOP_FORCE: assert property (@(posedge clk) disable iff (rst)
    force_stop |=> pd); // R6
  AST_MIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    $fell(pd) |-> (age >= CW'(HOLD_CYCLES))); // R7
  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(pd) |-> $past(!req_sw && !force_stop)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err |=> err); // R5
endmodule

// File: rtl/clkpath_pd_ctrl.sv
module clkpath_pd_ctrl
  import clkpath_pd_pkg::*;
#(
  parameter int HOLD_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [1:0]        pll_a_mode,
  input  logic [1:0]        pll_b_mode,
  input  logic [A_PATHS-1:0] gate_open_a,
  input  logic              gate_open_b,
  output logic [A_PATHS-1:0] pd_a,
  output logic              pd_b
);
  logic [A_PATHS-1:0] sw_a;
  logic               sw_b;
  logic [A_PATHS-1:0] err_a;
  logic               err_b;
  logic               stop_a;
  logic               stop_b;
  logic [DATA_W-1:0]  status;

  assign stop_a = (pll_mode_e'(pll_a_mode) == MODE_STOP);
  assign stop_b = (pll_mode_e'(pll_b_mode) == MODE_STOP);

  always_comb begin
    status                     = '0;
    status[A_PATHS-1:0]        = pd_a;
    status[A_PATHS]            = pd_b;
    status[ERR_LSB +: A_PATHS] = err_a;
    status[ERR_LSB + A_PATHS]  = err_b;
  end

  clkpath_pd_regs #(
    .N_A(A_PATHS), .LSB_A(A_LSB), .BIT_B(B_BIT)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .status(status), .sw_a(sw_a), .sw_b(sw_b), .rdata(reg_rdata)
  );

  for (genvar i = 0; i < A_PATHS; i++) begin : g_path_a
    clkpath_pd_path #(.HOLD_CYCLES(HOLD_CYCLES)) u_path (
      .clk(clk), .rst(rst), .req_sw(sw_a[i]), .force_stop(stop_a),
      .gate_open(gate_open_a[i]), .pd(pd_a[i]), .err(err_a[i])
    );
  end

  clkpath_pd_path #(.HOLD_CYCLES(HOLD_CYCLES)) u_path_b (
    .clk(clk), .rst(rst), .req_sw(sw_b), .force_stop(stop_b),
    .gate_open(gate_open_b), .pd(pd_b), .err(err_b)
  );

  AST_STOP_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    (stop_a && !$past(stop_a) && (err_a == '0)) |=> (err_a == '0)); // R6
endmodule

// File: tb/clkpath_pd_ctrl_test.sv
`timescale 1ns/1ps
module clkpath_pd_ctrl_test;
  localparam int HOLD = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  pll_a_mode = 2'b11;
  logic [1:0]  pll_b_mode = 2'b11;
  logic [4:0]  gate_open_a = '0;
  logic        gate_open_b = 1'b0;
  logic [4:0]  pd_a;
  logic        pd_b;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  clkpath_pd_ctrl #(.HOLD_CYCLES(HOLD)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pll_a_mode(pll_a_mode),
    .pll_b_mode(pll_b_mode), .gate_open_a(gate_open_a),
    .gate_open_b(gate_open_b), .pd_a(pd_a), .pd_b(pd_b)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
    tick(1);
  endtask

  function automatic logic [31:0] set_word(input int p);
    return (p < 5) ? (32'h1 << (27 + p)) : (32'h1 << 12);
  endfunction

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    @(negedge clk);
    do_reset();

    // R9: reset state
    chk("R9 pd", {26'd0, pd_b, pd_a}, 32'h0);
    rd(2'd2, d); chk("R9 status", d, 32'h0);
    rd(2'd0, d); chk("R9 ctrl A", d, 32'h0);

    // R3 / R1 / R2 / R8
    wr(2'd0, 32'hFFFF_FFFF);
    tick(1);
    chk("R3 all A down", {27'd0, pd_a}, 32'h1F);
    chk("R8 B untouched", {31'd0, pd_b}, 32'h0);
    rd(2'd0, d); chk("R1 ctrl A readback", d, 32'hF800_0000);
    wr(2'd1, 32'hFFFF_FFFF);
    tick(1);
    chk("R3 B down", {31'd0, pd_b}, 32'h1);
    rd(2'd1, d); chk("R1 ctrl B readback", d, 32'h0000_1000);
    rd(2'd2, d); chk("R2 status all down", d, 32'h0000_003F);
    rd(2'd3, d); chk("R1 unused address", d, 32'h0);
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0);
    tick(HOLD + 2);
    chk("R7 all released", {26'd0, pd_b, pd_a}, 32'h0);

    // R7 / R8: exact hold window per path
    for (int p = 0; p < 6; p++) begin
      wr((p < 5) ? 2'd0 : 2'd1, set_word(p));
      tick(1);
      chk("R8 one-hot rise", {26'd0, pd_b, pd_a}, 32'h1 << p);
      wr((p < 5) ? 2'd0 : 2'd1, 32'h0);
      for (int k = 2; k < HOLD; k++) begin
        tick(1);
        chk("R7 held", {26'd0, pd_b, pd_a}, 32'h1 << p);
      end
      tick(1);
      chk("R7 release at hold end", {26'd0, pd_b, pd_a}, 32'h0);
    end

    // R8: sweep every PLL A request pattern
    for (int p = 0; p < 32; p++) begin
      wr(2'd0, 32'(p) << 27);
      tick(HOLD + 2);
      chk("R8 sweep", {27'd0, pd_a}, 32'(p));
    end
    rd(2'd2, d); chk("R5 no error in sweep", d & 32'h3F00, 32'h0);
    wr(2'd0, 32'h0);
    tick(HOLD + 2);

    // R4 / R5: open gate holds request pending
    gate_open_a = 5'b00100;
    wr(2'd0, (32'h1 << 27) | (32'h1 << 29));
    tick(1);
    chk("R4 open gate pending", {27'd0, pd_a}, 32'h01);
    tick(3);
    chk("R4 still pending", {27'd0, pd_a}, 32'h01);
    rd(2'd2, d); chk("R5 error set", d, 32'h0000_0401);
    gate_open_a = 5'b00000;
    tick(1);
    chk("R4 rise after gate close", {27'd0, pd_a}, 32'h05);
    rd(2'd2, d); chk("R5 error kept", d, 32'h0000_0405);
    wr(2'd0, 32'h0);
    tick(HOLD + 2);
    rd(2'd2, d); chk("R5 sticky after clear", d, 32'h0000_0400);
    gate_open_b = 1'b1;
    wr(2'd1, 32'h0000_1000);
    tick(2);
    chk("R4 B pending", {31'd0, pd_b}, 32'h0);
    rd(2'd2, d); chk("R5 B error", d, 32'h0000_2400);
    wr(2'd1, 32'h0);
    gate_open_b = 1'b0;
    do_reset();
    rd(2'd2, d); chk("R5 cleared by reset", d, 32'h0);

    // R6: stop mode
    gate_open_a = 5'b11111;
    gate_open_b = 1'b1;
    pll_a_mode = 2'b00;
    tick(1);
    chk("R6 stop A forces", {27'd0, pd_a}, 32'h1F);
    chk("R6 B unaffected", {31'd0, pd_b}, 32'h0);
    tick(HOLD + 2);
    rd(2'd2, d); chk("R6 held, no error", d, 32'h0000_001F);
    pll_a_mode = 2'b11;
    tick(2);
    chk("R6 released after stop", {27'd0, pd_a}, 32'h0);
    for (int m = 1; m < 4; m++) begin
      pll_a_mode = 2'(m);
      tick(3);
      chk("R6 non-stop mode", {27'd0, pd_a}, 32'h0);
    end
    pll_b_mode = 2'b00;
    tick(1);
    chk("R6 stop B forces", {26'd0, pd_b, pd_a}, 32'h20);
    pll_b_mode = 2'b11;
    tick(HOLD + 2);
    chk("R6 B released", {26'd0, pd_b, pd_a}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule